// File: doc/BRIEF.md
# Sigma-Delta Bitstream Rectifier

This block takes the one-bit output of a sigma-delta modulator, one sample per valid strobe, and turns it into a unipolar 0/1 stream. The running average of that stream follows the amplitude of the signal the modulator is converting. A later filter stage can average it to get an envelope estimate without decimating the stream first. Each output bit is chosen by matching patterns in a short sliding window of modulator bits. No multi-bit arithmetic sits on the data path.

A mode input picks the modulator family. In first-order mode only the two-sample neighbour rule applies. In high-order mode a four-sample pattern detector is added. It spots the zero-mean bursts that a third-order modulator produces for small inputs, and it forces the affected outputs to zero. Each output appears a fixed number of accepted samples after its own sample, and outputs come out in sample order.

Top module: `sdm_bitstream_rectifier`

## Requirements
- R1: Modulator bits are encoded as 1 for +1 and 0 for -1. Unless overridden, the output for sample n is 1 when samples n and n+1 are equal and 0 when they differ.
- R2: With `mode_hi` = 0 (first-order mode), every output is given by the R1 rule alone, whatever the pattern. The mode is taken with the sample that completes each four-sample window.
- R3: With `mode_hi` = 1, the pattern 1,1,0,0 starting at sample n (samples n..n+3, in arrival order) forces the outputs for samples n, n+1 and n+2 to 0.
- R4: With `mode_hi` = 1, the pattern 0,0,1,1 starting at sample n forces the outputs for samples n, n+1 and n+2 to 0.
- R5: Overlapping or back-to-back long patterns combine. An output is 0 if any long pattern starting at n-2, n-1 or n covers it.
- R6: The output for sample n is presented with `out_valid` high for exactly one cycle. That cycle is the one after the clock edge that accepts sample n+3, and outputs appear in sample order.
- R7: Cycles with `in_valid` low do not move the window, do not advance the pattern override and produce no `out_valid`.
- R8: After reset, `out_valid` and `out_bit` are 0, the first three samples give no output, and no pattern seen before the reset affects later outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: `in_bit` holds a new modulator sample |
| in_bit | input | 1 | Modulator sample, 1 = +1, 0 = -1 |
| mode_hi | input | 1 | 0 = first-order mode, 1 = high-order mode with pattern override |
| out_valid | output | 1 | Strobe: `out_bit` holds a rectified sample |
| out_bit | output | 1 | Rectified bit |

## Verification
A window that has slipped by one position shows up at once: the first output after the fill appears one accepted sample early or late, or pairs the wrong neighbours, and several R1 values change within the first few outputs. A stuck or stale override mask is subtler. It shows only at outputs one or two samples after a long pattern, or, after a reset or a drop to first-order mode, at outputs that should follow the pair rule. For that reason the vectors put a long pattern close to the end of the window and run the same stream in both modes. A fill counter fault shows as a valid output before the fourth sample or a missing first output.

// File: rtl/sdm_rect_pkg.sv
package sdm_rect_pkg;

   typedef enum logic {
      ORDER_FIRST = 1'b0,
      ORDER_HIGH  = 1'b1
   } order_e;

   // Level for a neighbour pair: equal bits carry amplitude, differing bits do not.
   function automatic logic pair_level(input logic older, input logic newer);
      return ~(older ^ newer);
   endfunction

endpackage

// File: rtl/sdm_rect_window.sv
module sdm_rect_window #(
   parameter int WIN = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic           in_bit,
   output logic [WIN-1:0] win_next,
   output logic           win_full
);
   localparam int FILL_W = (WIN > 2) ? $clog2(WIN) : 1;
   localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WIN - 1);

   if (WIN < 2) begin : g_bad_win
      $error("sdm_rect_window: WIN must be at least 2");
   end

   logic [WIN-1:0]    win_q;
   logic [FILL_W-1:0] fill_q;

   // Oldest sample sits at the MSB, newest at the LSB.
   always_comb begin
      win_next = {win_q[WIN-2:0], in_bit};
      win_full = in_valid && (fill_q == FILL_MAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (in_valid) begin
         win_q <= win_next;
         if (fill_q != FILL_MAX) begin
            fill_q <= fill_q + 1'b1;
         end
      end
   end

   // R7
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(win_q));

   // R6
   newest_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> win_q[0] == $past(in_bit));

endmodule

// File: rtl/sdm_rect_override.sv
module sdm_rect_override
   import sdm_rect_pkg::*;
#(
   parameter int           WIN   = 4,
   parameter bit           EN    = 1'b1,
   parameter logic [WIN-1:0] PAT_A = 4'b1100,
   parameter logic [WIN-1:0] PAT_B = 4'b0011
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           step,
   input  order_e         order,
   input  logic [WIN-1:0] win_next,
   output logic           force_zero
);
   localparam int MASK_W = WIN - 2;

   if (WIN < 3) begin : g_bad_win
      $error("sdm_rect_override: WIN must be at least 3");
   end

   if (EN) begin : g_mask
      logic              hit;
      logic [MASK_W-1:0] mask_q;

      always_comb begin
         hit        = (order == ORDER_HIGH) && ((win_next == PAT_A) || (win_next == PAT_B));
         force_zero = (order == ORDER_HIGH) && (hit || mask_q[0]);
      end

      // Bit i of the mask clears the output i+1 steps ahead.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q <= '0;
         end else if (step) begin
            if (order == ORDER_HIGH) begin
               mask_q <= (mask_q >> 1) | {MASK_W{hit}};
            end else begin
               mask_q <= '0;
            end
         end
      end

      // R2
      first_order_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (step && order == ORDER_FIRST) |=> mask_q == '0);

      // R5
      mask_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (step && !hit) |=> $countones(mask_q) <= $countones($past(mask_q)));
   end else begin : g_no_mask
      always_comb force_zero = 1'b0;
   end

endmodule

// File: rtl/sdm_bitstream_rectifier.sv
module sdm_bitstream_rectifier
   import sdm_rect_pkg::*;
#(
   parameter int        WIN         = 4,
   parameter bit        OVERRIDE_EN = 1'b1,
   parameter logic [WIN-1:0] PAT_A  = 4'b1100,
   parameter logic [WIN-1:0] PAT_B  = 4'b0011
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_bit,
   input  logic mode_hi,
   output logic out_valid,
   output logic out_bit
);
   if (WIN != 4) begin : g_bad_win
      $error("sdm_bitstream_rectifier: pattern window must be 4 samples");
   end

   logic [WIN-1:0] win_next;
   logic           win_full;
   logic           force_zero;
   logic           level;
   order_e         order;

   always_comb order = order_e'(mode_hi);

   sdm_rect_window #(.WIN(WIN)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_bit   (in_bit),
      .win_next (win_next),
      .win_full (win_full)
   );

   sdm_rect_override #(
      .WIN   (WIN),
      .EN    (OVERRIDE_EN),
      .PAT_A (PAT_A),
      .PAT_B (PAT_B)
   ) u_override (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (win_full),
      .order      (order),
      .win_next   (win_next),
      .force_zero (force_zero)
   );

   always_comb level = pair_level(win_next[WIN-1], win_next[WIN-2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_bit   <= 1'b0;
      end else begin
         out_valid <= win_full;
         if (win_full) begin
            out_bit <= level && !force_zero;
         end
      end
   end

   // R3
   forced_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_full && force_zero) |=> (out_valid && !out_bit));

   // R7
   idle_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R8
   fill_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !win_full) |=> !out_valid);

   // R6
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

endmodule

// File: tb/sdm_bitstream_rectifier_test.sv
`timescale 1ns/100ps
module sdm_bitstream_rectifier_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_bit = 1'b0;
   logic mode_hi = 1'b0;
   logic out_valid;
   logic out_bit;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic got [0:63];
   int   got_n = 0;

   always #2.5 clk = ~clk;

   sdm_bitstream_rectifier uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_bit    (in_bit),
      .mode_hi   (mode_hi),
      .out_valid (out_valid),
      .out_bit   (out_bit)
   );

   // {mode, 8 samples first-to-last from MSB, 5 expected outputs sample 0 at MSB}
   localparam int NV = 10;
   localparam logic [13:0] VEC [NV] = '{
      {1'b0, 8'b10101010, 5'b00000},  // R1 alternating
      {1'b0, 8'b11110000, 5'b11101},  // R1 R2 runs
      {1'b1, 8'b11001100, 5'b00000},  // R3 R4 R5 chained patterns
      {1'b0, 8'b11001100, 5'b10101},  // R2 same stream, no override
      {1'b1, 8'b11110000, 5'b11000},  // R3 late pattern
      {1'b1, 8'b00111111, 5'b00011},  // R4 leading pattern
      {1'b0, 8'b00111111, 5'b10111},  // R2
      {1'b1, 8'b01010101, 5'b00000},  // R1 high mode, no pattern
      {1'b1, 8'b11100011, 5'b10000},  // R3 R4 R5 adjacent patterns
      {1'b0, 8'b11100011, 5'b11011}   // R2
   };

   function automatic string vec_tag(input int i);
      case (i)
         0, 7:       return "R1";
         1, 3, 6, 9: return "R2";
         2, 8:       return "R5";
         4:          return "R3";
         default:    return "R4";
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && out_valid && got_n < 64) begin
         got[got_n] = out_bit;
         got_n++;
      end
   end

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      got_n = 0;
   endtask

   task automatic send(input logic b, input int gap);
      @(negedge clk);
      in_valid = 1'b1;
      in_bit = b;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic run_vec(input int i, input int gap);
      logic [7:0] s;
      logic [4:0] e;
      s = VEC[i][12:5];
      e = VEC[i][4:0];
      do_reset();
      mode_hi = VEC[i][13];
      for (int k = 7; k >= 0; k--) send(s[k], gap);
      repeat (3) @(negedge clk);
      check_int(vec_tag(i), got_n, 5, $sformatf("vector %0d output count", i));
      for (int k = 0; k < 5 && k < got_n; k++)
         check(vec_tag(i), got[k], e[4-k], $sformatf("vector %0d gap %0d sample %0d", i, gap, k));
   endtask

   initial begin
      // R8 reset state
      repeat (3) @(negedge clk);
      check("R8", out_valid, 1'b0, "out_valid in reset");
      check("R8", out_bit, 1'b0, "out_bit in reset");
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) run_vec(i, 0);

      // R7 idle gaps between samples change nothing
      run_vec(2, 3);
      run_vec(8, 2);

      // R6 R8 latency: no output through the third sample, output right after the fourth
      do_reset();
      mode_hi = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_bit = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      check("R8", out_valid, 1'b0, "out_valid after three samples");
      repeat (2) @(negedge clk);
      check("R8", out_valid, 1'b0, "out_valid while idle after fill");
      in_valid = 1'b1;
      in_bit = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R6", out_valid, 1'b1, "out_valid one cycle after fourth sample");
      check("R6", out_bit, 1'b1, "first output value");
      @(negedge clk);
      check("R6", out_valid, 1'b0, "out_valid single cycle");

      // R8 pattern before reset must be forgotten
      do_reset();
      mode_hi = 1'b1;
      send(1'b1, 0); send(1'b1, 0); send(1'b0, 0); send(1'b0, 0);
      repeat (2) @(negedge clk);
      check("R3", got[0], 1'b0, "pattern output before reset");
      do_reset();
      for (int k = 0; k < 5; k++) send(1'b0, 0);
      repeat (2) @(negedge clk);
      check_int("R8", got_n, 2, "outputs after reset");
      check("R8", got[0], 1'b1, "first output after reset");
      check("R8", got[1], 1'b1, "second output after reset");

      // R2 dropping to first-order mode mid-stream clears pending override
      do_reset();
      mode_hi = 1'b1;
      send(1'b1, 0); send(1'b1, 0); send(1'b0, 0); send(1'b0, 0);
      mode_hi = 1'b0;
      send(1'b0, 0); send(1'b1, 0);
      repeat (2) @(negedge clk);
      check_int("R2", got_n, 3, "outputs around mode change");
      check("R3", got[0], 1'b0, "forced sample before mode change");
      check("R2", got[1], 1'b0, "pair differs after mode change");
      check("R2", got[2], 1'b1, "pair equal after mode change");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule